// File: doc/BRIEF.md
# Cascadable Priority Encoder

This block turns a bank of active-low request lines into the active-low binary index of the highest-numbered request that is asserted. Requests with lower indices are ignored. The block has no registers. Each eight-way cell has an active-low enable input and two active-low status flags. The idle flag is low when the cell is enabled and sees no request. The group flag is low when the cell is enabled and sees at least one request.

The top module chains several cells into one wider encoder. The topmost cell takes the external enable. Each lower cell is enabled by the idle flag of the cell above it, so only one cell in the chain can be reporting at a time. With the default parameters, two cells form a 16-input encoder with a 4-bit code. The low code bits are the bitwise AND of the cells' active-low codes. The high code bits are the index of the reporting cell, inverted to active-low.

Top module: `prio_enc_cascade`

## Requirements
- R1: With enable low and exactly one request line k low (requests are active-low), `code_no` equals the bitwise inverse of k as an unsigned binary number.
- R2: With several request lines low, the code reflects the line with the largest index only. Lines with smaller indices have no effect on any output.
- R3: With `en_ni` high, `code_no` is all ones and `eo_no` and `gs_no` are both high, whatever the request lines carry.
- R4: `eo_no` is low exactly when `en_ni` is low and every request line is high.
- R5: `gs_no` is low exactly when `en_ni` is low and at least one request line is low.
- R6: With `en_ni` low and no request low, `code_no` is all ones.
- R7: A request in the upper cell always wins over any request in the lower cell. The lower cell is enabled only while the upper cell is enabled and idle, so at most one cell reports a group hit at a time.
- R8: The most significant code bit (for two cells) is low exactly when the winning request lies in the upper eight lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_ni | input | 16 | Active-low request lines; bit 15 has the highest priority |
| en_ni | input | 1 | Active-low enable |
| code_no | output | 4 | Active-low binary index of the winning request |
| eo_no | output | 1 | Active-low flag: enabled and no request |
| gs_no | output | 1 | Active-low flag: enabled and at least one request |

## Verification
The block holds no state, so a wrong internal value shows at the ports in the same evaluation in which its inputs are applied. A broken enable link between the cells would let a lower request change the code while an upper request is active. It would also leave both cells reporting a hit at once. Both show up as a wrong code bit or as two group flags low together. A faulty priority scan inside a cell gives a wrong low code for patterns that have several requests active. Sweeping every pattern of each byte catches it on the first such pattern.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
  localparam int unsigned CELL_WAY  = 8;
  localparam int unsigned CELL_CODE = $clog2(CELL_WAY);
endpackage

// File: rtl/prio_enc_cell.sv
module prio_enc_cell #(
  parameter int unsigned WAY    = prio_enc_pkg::CELL_WAY,
  parameter int unsigned CODE_W = $clog2(WAY)
) (
  input  logic [WAY-1:0]    req_ni,
  input  logic              en_ni,
  output logic [CODE_W-1:0] code_no,
  output logic              eo_no,
  output logic              gs_no
);
  logic              hit;
  logic [CODE_W-1:0] idx;

  // ascending scan: the last (highest) active line overwrites earlier ones
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < WAY; i++) begin
      if (!req_ni[i]) begin
        hit = 1'b1;
        idx = CODE_W'(i);
      end
    end
  end

  assign code_no = en_ni ? '1 : ~idx;
  assign eo_no   = en_ni | hit;
  assign gs_no   = en_ni | ~hit;

  always_comb begin
    if (en_ni) AST_DISABLED_QUIET: assert (&{code_no, eo_no, gs_no}); // R3
    if (!en_ni) AST_FLAGS_EXCL: assert (eo_no ^ gs_no); // R4
    if (!eo_no) AST_IDLE_CODE: assert (&code_no); // R6
    if (!gs_no) AST_GS_HAS_REQ: assert (!(&req_ni)); // R5
  end
endmodule

// File: rtl/prio_enc_cascade.sv
module prio_enc_cascade #(
  parameter int unsigned WAY    = prio_enc_pkg::CELL_WAY,
  parameter int unsigned STAGES = 2,
  localparam int unsigned CELL_W = $clog2(WAY),
  localparam int unsigned SEL_W  = $clog2(STAGES),
  localparam int unsigned IN_W   = WAY * STAGES,
  localparam int unsigned OUT_W  = CELL_W + SEL_W
) (
  input  logic [IN_W-1:0]  req_ni,
  input  logic             en_ni,
  output logic [OUT_W-1:0] code_no,
  output logic             eo_no,
  output logic             gs_no
);
  logic [STAGES-1:0]             en_n;
  logic [STAGES-1:0]             eo_n;
  logic [STAGES-1:0]             gs_n;
  logic [STAGES-1:0][CELL_W-1:0] cell_code_n;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == STAGES - 1) begin : g_top
      assign en_n[s] = en_ni;
    end else begin : g_chain
      assign en_n[s] = eo_n[s+1];
    end
    prio_enc_cell #(.WAY(WAY), .CODE_W(CELL_W)) u_cell (
      .req_ni  (req_ni[s*WAY +: WAY]),
      .en_ni   (en_n[s]),
      .code_no (cell_code_n[s]),
      .eo_no   (eo_n[s]),
      .gs_no   (gs_n[s])
    );
  end

  logic [CELL_W-1:0] low_n;
  logic [SEL_W-1:0]  sel;

  // idle or disabled cells drive all ones, so AND merges the codes
  always_comb begin
    low_n = '1;
    sel   = '0;
    for (int s = 0; s < STAGES; s++) begin
      low_n = low_n & cell_code_n[s];
      if (!gs_n[s]) sel = sel | SEL_W'(s);
    end
  end

  assign code_no = {~sel, low_n};
  assign eo_no   = eo_n[0];
  assign gs_no   = &gs_n;

  always_comb begin
    AST_ONE_CELL_HIT: assert ($onehot0(~gs_n)); // R7
    if (!gs_n[STAGES-1]) AST_LOWER_HELD: assert (en_n[0] || STAGES == 1); // R7
    if (en_ni) AST_TOP_QUIET: assert (&{code_no, eo_no, gs_no}); // R3
  end
endmodule

// File: tb/prio_enc_cascade_tb.sv
module prio_enc_cascade_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_ni = '1;
  logic        en_ni = 1'b1;
  logic [3:0]  code_no;
  logic        eo_no;
  logic        gs_no;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  prio_enc_cascade u_dut (
    .req_ni  (req_ni),
    .en_ni   (en_ni),
    .code_no (code_no),
    .eo_no   (eo_no),
    .gs_no   (gs_no)
  );

  // {en, req, code, eo, gs}
  localparam int NVEC = 12;
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b0, 16'hFFFF, 4'hF, 1'b0, 1'b1},
    {1'b0, 16'h7FFF, 4'h0, 1'b1, 1'b0},
    {1'b0, 16'hFFFE, 4'hF, 1'b1, 1'b0},
    {1'b0, 16'hFEFF, 4'h7, 1'b1, 1'b0},
    {1'b0, 16'hFF7F, 4'h8, 1'b1, 1'b0},
    {1'b0, 16'h0000, 4'h0, 1'b1, 1'b0},
    {1'b0, 16'hFF00, 4'h8, 1'b1, 1'b0},
    {1'b0, 16'h00FF, 4'h0, 1'b1, 1'b0},
    {1'b0, 16'hEFFE, 4'h3, 1'b1, 1'b0},
    {1'b1, 16'h0000, 4'hF, 1'b1, 1'b1},
    {1'b0, 16'hFFEF, 4'hB, 1'b1, 1'b0},
    {1'b0, 16'hBFFF, 4'h1, 1'b1, 1'b0}
  };

  function automatic logic [5:0] model(input logic en, input logic [15:0] req);
    if (en) return 6'h3F;
    for (int i = 15; i >= 0; i--)
      if (!req[i]) return {~4'(i), 1'b1, 1'b0};
    return {4'hF, 1'b0, 1'b1};
  endfunction

  task automatic apply_check(input logic en, input logic [15:0] req,
                             input logic [5:0] exp, input string tag);
    @(posedge clk);
    #1;
    en_ni  = en;
    req_ni = req;
    #3;
    n_checks++;
    if ({code_no, eo_no, gs_no} !== exp) begin
      n_fail++;
      $display("FAIL %s en=%b req=%h actual=%h expected=%h", tag, en, req,
               {code_no, eo_no, gs_no}, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // reset state, R3: disabled encoder is fully quiet
    apply_check(1'b1, 16'h0000, 6'h3F, "R3 reset");
    rst_ni = 1'b1;
    // directed table: R7 cascade priority, R8 stage bit, R6 idle, R2
    for (int v = 0; v < NVEC; v++)
      apply_check(VEC[v][22], VEC[v][21:6], VEC[v][5:0], "R7_R8 table");
    // low cell sweep with upper idle: R1 R2 R4 R5 R6
    for (int p = 0; p < 256; p++)
      apply_check(1'b0, {8'hFF, 8'(p)}, model(1'b0, {8'hFF, 8'(p)}), "R1_R2_R5 low");
    // upper cell sweep with busy lower cell: R7 R8 R2
    for (int p = 0; p < 256; p++)
      apply_check(1'b0, {8'(p), 8'(p) ^ 8'h5A}, model(1'b0, {8'(p), 8'(p) ^ 8'h5A}),
                  "R7_R8 high");
    // disabled sweep: R3
    for (int p = 0; p < 256; p++)
      apply_check(1'b1, {8'(p), ~8'(p)}, 6'h3F, "R3 disabled");
    // R4 idle flag, R6 idle code
    apply_check(1'b0, 16'hFFFF, {4'hF, 1'b0, 1'b1}, "R4_R6 idle");
    finish_run();
  end
endmodule